// File: doc/BRIEF.md
# In-Order Multi-Resource Issue Scoreboard

This block sits between an in-order stream of operation descriptors and three execution resources: a main compute context, a secondary data-movement context and a DMA engine. Every descriptor names its target resource and carries one write address range and two read address ranges, each given as a base and a length. The block holds the descriptor at the head of the stream until the descriptor can run safely. The target resource must be idle, and no range of the descriptor may collide with a range of any operation still in flight. Only then does the block accept the descriptor and dispatch it.

The block keeps one in-flight slot per resource. An accepted descriptor fills the slot of its resource and stays visible to hazard checks from the next cycle on. A completion pulse from a resource frees that slot in the cycle the pulse is seen. The block inserts every wait itself, so the stream carries no barrier operations. Completions may arrive in any order across the three resources, but descriptors never leave out of order.

Top module: `issue_scoreboard`

## Requirements
- R1: After a synchronous active-high reset, `disp_valid` is 0 and all slots are empty, so a presented descriptor with a valid resource code sees `op_ready` high.
- R2: Resource codes are 0 = main, 1 = sub, 2 = DMA. A descriptor whose resource holds an in-flight operation keeps `op_ready` low. The next cycle after that resource's `res_done` pulse, `op_ready` is high.
- R3: Operations on different resources with disjoint ranges are accepted back to back and can all be in flight at once.
- R4: Read after write: if either read range of the head overlaps the write range of an in-flight operation, `op_ready` stays low. This holds from the cycle right after that operation was accepted.
- R5: Write after read: if the head's write range overlaps either read range of an in-flight operation, `op_ready` stays low.
- R6: Write after write: if the head's write range overlaps the write range of an in-flight operation, `op_ready` stays low.
- R7: While the head is stalled, no `disp_valid` bit rises, not even for idle resources. Nothing behind the head can be dispatched ahead of it.
- R8: Ranges [b, b+l) overlap only when both lengths are non-zero and each base is below the other range's end. Adjacent ranges and zero-length ranges never conflict.
- R9: If the head targets a resource in the cycle that resource pulses `res_done`, the head is accepted in that same cycle and refills the freed slot.
- R10: One cycle after acceptance, exactly the `disp_valid` bit of the target resource is high for one cycle, and the `disp_*` range outputs carry that descriptor's ranges.
- R11: Completions are handled out of order. A `res_done` pulse frees only the slot of its own resource.
- R12: Resource code 3 is never accepted.
- R13: A `res_done` pulse for a resource with no operation in flight has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Head descriptor present |
| op_ready | output | 1 | Head descriptor may issue this cycle |
| op_res | input | 2 | Target resource code |
| op_wr_base | input | 16 | Write range base |
| op_wr_len | input | 16 | Write range length |
| op_rd0_base | input | 16 | First read range base |
| op_rd0_len | input | 16 | First read range length |
| op_rd1_base | input | 16 | Second read range base |
| op_rd1_len | input | 16 | Second read range length |
| res_done | input | 3 | Per-resource completion pulses |
| disp_valid | output | 3 | Per-resource dispatch pulse |
| disp_wr_base | output | 16 | Dispatched write base |
| disp_wr_len | output | 16 | Dispatched write length |
| disp_rd0_base | output | 16 | Dispatched first read base |
| disp_rd0_len | output | 16 | Dispatched first read length |
| disp_rd1_base | output | 16 | Dispatched second read base |
| disp_rd1_len | output | 16 | Dispatched second read length |

## Verification
The main function is driven with patterns that separate the possible causes of a stall:
- A busy target with disjoint ranges isolates the resource check.
- Pairs that collide only read-on-write, only write-on-read or only write-on-write each exercise one hazard comparator, and the read-after-write pair uses the second read port.
- Ranges that touch at one boundary, or whose length is zero, separate a true overlap from an off-by-one in the end compare.
- A completion that arrives together with a new issue, and completions on idle resources, show that a slot is freed in the right cycle and only for its own resource.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // configuration point for all widths and counts
  parameter int SB_ADDR_W  = 16;
  parameter int SB_LEN_W   = 16;
  parameter int SB_NUM_RES = 3;
  localparam int SB_RES_W  = (SB_NUM_RES > 1) ? $clog2(SB_NUM_RES) : 1;
  localparam int SB_SUM_W  = ((SB_ADDR_W > SB_LEN_W) ? SB_ADDR_W : SB_LEN_W) + 1;

  typedef enum logic [SB_RES_W-1:0] {
    RES_MAIN = 0,
    RES_SUB  = 1,
    RES_DMA  = 2
  } sb_res_e;

  typedef struct packed {
    logic [SB_ADDR_W-1:0] base;
    logic [SB_LEN_W-1:0]  len;
  } sb_rng_t;

  typedef struct packed {
    sb_rng_t wr;
    sb_rng_t rd0;
    sb_rng_t rd1;
  } sb_entry_t;

  // end of a range, widened so it cannot wrap
  function automatic logic [SB_SUM_W-1:0] rng_end(sb_rng_t r);
    return SB_SUM_W'(r.base) + SB_SUM_W'(r.len);
  endfunction

  // half-open interval intersection; empty ranges never intersect
  function automatic logic rng_overlap(sb_rng_t a, sb_rng_t b);
    logic nonempty;
    nonempty = (a.len != '0) && (b.len != '0);
    return nonempty && (SB_SUM_W'(a.base) < rng_end(b)) && (SB_SUM_W'(b.base) < rng_end(a));
  endfunction
endpackage

// File: rtl/sb_flight_slot.sv
module sb_flight_slot
  import sb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fill,
  input  logic      done,
  input  sb_entry_t fill_ent,
  input  sb_entry_t head,
  output logic      live_o,
  output logic      raw_o,
  output logic      war_o,
  output logic      waw_o
);
  logic      valid_q;
  sb_entry_t ent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ent_q   <= '0;
    end else if (fill) begin
      valid_q <= 1'b1;
      ent_q   <= fill_ent;
    end else if (done) begin
      valid_q <= 1'b0;
    end
  end

  // a completion seen this cycle already frees the slot
  assign live_o = valid_q & ~done;

  always_comb begin
    raw_o = live_o & (rng_overlap(head.rd0, ent_q.wr) | rng_overlap(head.rd1, ent_q.wr));
    war_o = live_o & (rng_overlap(head.wr, ent_q.rd0) | rng_overlap(head.wr, ent_q.rd1));
    waw_o = live_o & rng_overlap(head.wr, ent_q.wr);
  end

  // R2
  slot_fill_chk: assert property (@(posedge clk) disable iff (rst)
    fill |-> (!valid_q || done));

  // R13
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && done && !fill) |=> !valid_q);

  // R11
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && done && !fill) |=> !valid_q);
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_RES = SB_NUM_RES,
  parameter int RES_W   = SB_RES_W
) (
  input  logic               op_valid,
  input  logic [RES_W-1:0]   op_res,
  input  logic [NUM_RES-1:0] busy,
  input  logic [NUM_RES-1:0] haz,
  output logic               op_ready,
  output logic [NUM_RES-1:0] fill
);
  logic [NUM_RES-1:0] res_hit;
  logic               res_ok;
  logic               sel_busy;
  logic               haz_any;

  for (genvar i = 0; i < NUM_RES; i++) begin : g_dec
    assign res_hit[i] = (op_res == RES_W'(i));
    assign fill[i]    = op_valid & op_ready & res_hit[i];
  end

  assign res_ok   = |res_hit;
  assign sel_busy = |(busy & res_hit);
  assign haz_any  = |haz;
  assign op_ready = res_ok & ~sel_busy & ~haz_any;
endmodule

// File: rtl/sb_dispatch_reg.sv
module sb_dispatch_reg
  import sb_pkg::*;
#(
  parameter int NUM_RES = SB_NUM_RES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_RES-1:0] fill,
  input  sb_entry_t          ent,
  output logic [NUM_RES-1:0] disp_valid,
  output sb_entry_t          disp_ent
);
  logic issued;
  assign issued = |fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= '0;
      disp_ent   <= '0;
    end else begin
      disp_valid <= fill;
      if (issued) disp_ent <= ent;
    end
  end

  // R10
  disp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(disp_valid));

  // R10
  disp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid != '0) |-> $past(issued));
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_RES = SB_NUM_RES,
  parameter int ADDR_W  = SB_ADDR_W,
  parameter int LEN_W   = SB_LEN_W,
  parameter int RES_W   = SB_RES_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [RES_W-1:0]   op_res,
  input  logic [ADDR_W-1:0]  op_wr_base,
  input  logic [LEN_W-1:0]   op_wr_len,
  input  logic [ADDR_W-1:0]  op_rd0_base,
  input  logic [LEN_W-1:0]   op_rd0_len,
  input  logic [ADDR_W-1:0]  op_rd1_base,
  input  logic [LEN_W-1:0]   op_rd1_len,
  input  logic [NUM_RES-1:0] res_done,
  output logic [NUM_RES-1:0] disp_valid,
  output logic [ADDR_W-1:0]  disp_wr_base,
  output logic [LEN_W-1:0]   disp_wr_len,
  output logic [ADDR_W-1:0]  disp_rd0_base,
  output logic [LEN_W-1:0]   disp_rd0_len,
  output logic [ADDR_W-1:0]  disp_rd1_base,
  output logic [LEN_W-1:0]   disp_rd1_len
);
  sb_entry_t          head;
  sb_entry_t          disp_ent;
  logic [NUM_RES-1:0] live_v, raw_v, war_v, waw_v, haz_v, fill_v;

  assign head.wr.base  = op_wr_base;
  assign head.wr.len   = op_wr_len;
  assign head.rd0.base = op_rd0_base;
  assign head.rd0.len  = op_rd0_len;
  assign head.rd1.base = op_rd1_base;
  assign head.rd1.len  = op_rd1_len;

  for (genvar i = 0; i < NUM_RES; i++) begin : g_slot
    sb_flight_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .fill     (fill_v[i]),
      .done     (res_done[i]),
      .fill_ent (head),
      .head     (head),
      .live_o   (live_v[i]),
      .raw_o    (raw_v[i]),
      .war_o    (war_v[i]),
      .waw_o    (waw_v[i])
    );
    assign haz_v[i] = raw_v[i] | war_v[i] | waw_v[i];

    // R2
    busy_issue_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_ready && op_res == RES_W'(i)) |-> !live_v[i]);
  end

  sb_issue_ctrl #(.NUM_RES(NUM_RES), .RES_W(RES_W)) u_ctrl (
    .op_valid (op_valid),
    .op_res   (op_res),
    .busy     (live_v),
    .haz      (haz_v),
    .op_ready (op_ready),
    .fill     (fill_v)
  );

  sb_dispatch_reg #(.NUM_RES(NUM_RES)) u_disp (
    .clk        (clk),
    .rst        (rst),
    .fill       (fill_v),
    .ent        (head),
    .disp_valid (disp_valid),
    .disp_ent   (disp_ent)
  );

  assign disp_wr_base  = disp_ent.wr.base;
  assign disp_wr_len   = disp_ent.wr.len;
  assign disp_rd0_base = disp_ent.rd0.base;
  assign disp_rd0_len  = disp_ent.rd0.len;
  assign disp_rd1_base = disp_ent.rd1.base;
  assign disp_rd1_len  = disp_ent.rd1.len;

  // R4
  raw_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |-> (raw_v == '0));

  // R5
  war_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |-> (war_v == '0));

  // R6
  waw_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |-> (waw_v == '0));

  // R12
  bad_res_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_res == RES_W'(3)) |-> !op_ready);

  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_ready) |=> (disp_valid == '0));
endmodule

// File: tb/issue_scoreboard_tb.sv
module issue_scoreboard_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_res = '0;
  logic [15:0] op_wr_base = '0, op_wr_len = '0;
  logic [15:0] op_rd0_base = '0, op_rd0_len = '0;
  logic [15:0] op_rd1_base = '0, op_rd1_len = '0;
  logic [2:0]  res_done = '0;
  logic [2:0]  disp_valid;
  logic [15:0] disp_wr_base, disp_wr_len, disp_rd0_base, disp_rd0_len, disp_rd1_base, disp_rd1_len;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  issue_scoreboard dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready), .op_res(op_res),
    .op_wr_base(op_wr_base), .op_wr_len(op_wr_len),
    .op_rd0_base(op_rd0_base), .op_rd0_len(op_rd0_len),
    .op_rd1_base(op_rd1_base), .op_rd1_len(op_rd1_len),
    .res_done(res_done), .disp_valid(disp_valid),
    .disp_wr_base(disp_wr_base), .disp_wr_len(disp_wr_len),
    .disp_rd0_base(disp_rd0_base), .disp_rd0_len(disp_rd0_len),
    .disp_rd1_base(disp_rd1_base), .disp_rd1_len(disp_rd1_len)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0; res_done = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  // present a descriptor just after a falling edge and let it settle
  task automatic put(input logic [1:0] r, input logic [15:0] wb, wl, r0b, r0l, r1b, r1l);
    op_valid = 1'b1; op_res = r;
    op_wr_base = wb; op_wr_len = wl;
    op_rd0_base = r0b; op_rd0_len = r0l;
    op_rd1_base = r1b; op_rd1_len = r1l;
    #1;
  endtask

  // present, expect acceptance, cross one rising edge
  task automatic issue(input string req, input logic [1:0] r, input logic [15:0] wb, wl, r0b, r0l, r1b, r1l);
    put(r, wb, wl, r0b, r0l, r1b, r1l);
    chk(req, "ready for issue", {31'd0, op_ready}, 32'd1);
    @(negedge clk);
    op_valid = 1'b0;
    #1;
  endtask

  task automatic pulse_done(input logic [2:0] d);
    res_done = d;
    @(negedge clk);
    res_done = '0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "disp_valid after reset", {29'd0, disp_valid}, 32'd0);
    put(2'd0, 16'h10, 16'h4, 16'h20, 16'h4, 16'h30, 16'h4);
    chk("R1", "ready after reset", {31'd0, op_ready}, 32'd1);
    op_valid = 1'b0;
  endtask

  task automatic t_dispatch();
    do_reset();
    issue("R10", 2'd2, 16'h1234, 16'h10, 16'h2000, 16'h8, 16'h3000, 16'h2);
    chk("R10", "dma pulse", {29'd0, disp_valid}, 32'd4);
    chk("R10", "wr base", {16'd0, disp_wr_base}, 32'h1234);
    chk("R10", "wr len", {16'd0, disp_wr_len}, 32'h10);
    chk("R10", "rd0 base", {16'd0, disp_rd0_base}, 32'h2000);
    chk("R10", "rd1 len", {16'd0, disp_rd1_len}, 32'h2);
    @(negedge clk); #1;
    chk("R10", "pulse lasts one cycle", {29'd0, disp_valid}, 32'd0);
  endtask

  task automatic t_busy();
    do_reset();
    issue("R2", 2'd0, 16'h100, 16'h10, 16'h0, 16'h0, 16'h0, 16'h0);
    put(2'd0, 16'h800, 16'h4, 16'h900, 16'h4, 16'h0, 16'h0);
    for (int k = 0; k < 3; k++) begin
      chk("R2", "busy main stalls", {31'd0, op_ready}, 32'd0);
      @(negedge clk); #1;
    end
    chk("R7", "no dispatch while stalled", {29'd0, disp_valid}, 32'd0);
    op_valid = 1'b0;
    pulse_done(3'b001);
    put(2'd0, 16'h800, 16'h4, 16'h900, 16'h4, 16'h0, 16'h0);
    chk("R2", "ready after done", {31'd0, op_ready}, 32'd1);
    op_valid = 1'b0;
  endtask

  task automatic t_parallel();
    do_reset();
    issue("R3", 2'd0, 16'h000, 16'h10, 16'h100, 16'h10, 16'h0, 16'h0);
    chk("R3", "main pulse", {29'd0, disp_valid}, 32'd1);
    issue("R3", 2'd1, 16'h200, 16'h10, 16'h300, 16'h10, 16'h0, 16'h0);
    chk("R3", "sub pulse", {29'd0, disp_valid}, 32'd2);
    issue("R3", 2'd2, 16'h400, 16'h10, 16'h500, 16'h10, 16'h0, 16'h0);
    chk("R3", "dma pulse", {29'd0, disp_valid}, 32'd4);
    // out of order completion: sub frees, main and dma stay busy
    pulse_done(3'b010);
    put(2'd0, 16'h600, 16'h1, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R11", "main still busy", {31'd0, op_ready}, 32'd0);
    put(2'd2, 16'h600, 16'h1, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R11", "dma still busy", {31'd0, op_ready}, 32'd0);
    put(2'd1, 16'h600, 16'h1, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R11", "sub freed", {31'd0, op_ready}, 32'd1);
    op_valid = 1'b0;
  endtask

  task automatic t_raw();
    do_reset();
    issue("R4", 2'd2, 16'h200, 16'h20, 16'h0, 16'h0, 16'h0, 16'h0);
    // cycle right after acceptance; hazard on second read port
    put(2'd0, 16'h700, 16'h4, 16'h0, 16'h0, 16'h21F, 16'h4);
    chk("R4", "raw stall visible next cycle", {31'd0, op_ready}, 32'd0);
    put(2'd0, 16'h700, 16'h4, 16'h210, 16'h4, 16'h0, 16'h0);
    chk("R4", "raw stall rd0", {31'd0, op_ready}, 32'd0);
    res_done = 3'b100;
    #1;
    chk("R4", "raw released by done", {31'd0, op_ready}, 32'd1);
    @(negedge clk);
    res_done = '0; op_valid = 1'b0;
    #1;
  endtask

  task automatic t_war();
    do_reset();
    issue("R5", 2'd1, 16'h900, 16'h4, 16'h0, 16'h0, 16'h300, 16'h8);
    put(2'd2, 16'h307, 16'h1, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R5", "war stall", {31'd0, op_ready}, 32'd0);
    put(2'd2, 16'h308, 16'h4, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R8", "adjacent write no conflict", {31'd0, op_ready}, 32'd1);
    put(2'd2, 16'h2FC, 16'h4, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R8", "range ending at base no conflict", {31'd0, op_ready}, 32'd1);
    op_valid = 1'b0;
  endtask

  task automatic t_waw();
    do_reset();
    issue("R6", 2'd0, 16'h400, 16'h10, 16'h0, 16'h0, 16'h0, 16'h0);
    put(2'd2, 16'h40F, 16'h1, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R6", "waw stall at last byte", {31'd0, op_ready}, 32'd0);
    @(negedge clk); #1;
    chk("R7", "idle dma not dispatched", {29'd0, disp_valid}, 32'd0);
    put(2'd2, 16'h3F0, 16'h20, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R6", "waw stall enclosing", {31'd0, op_ready}, 32'd0);
    op_valid = 1'b0;
  endtask

  task automatic t_zero();
    do_reset();
    issue("R8", 2'd0, 16'h500, 16'h10, 16'h500, 16'h10, 16'h0, 16'h0);
    put(2'd1, 16'h504, 16'h0, 16'h504, 16'h0, 16'h505, 16'h0);
    chk("R8", "zero length never conflicts", {31'd0, op_ready}, 32'd1);
    op_valid = 1'b0;
  endtask

  task automatic t_bad_res();
    do_reset();
    put(2'd3, 16'h10, 16'h1, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R12", "code 3 not ready", {31'd0, op_ready}, 32'd0);
    @(negedge clk); #1;
    chk("R12", "code 3 not dispatched", {29'd0, disp_valid}, 32'd0);
    op_valid = 1'b0;
  endtask

  task automatic t_idle_done();
    do_reset();
    issue("R13", 2'd0, 16'h10, 16'h1, 16'h0, 16'h0, 16'h0, 16'h0);
    pulse_done(3'b110);
    put(2'd0, 16'h20, 16'h1, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R13", "main unaffected by idle done", {31'd0, op_ready}, 32'd0);
    put(2'd1, 16'h10, 16'h1, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R13", "write-after-write still seen", {31'd0, op_ready}, 32'd0);
    put(2'd1, 16'h20, 16'h1, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R13", "sub idle ready", {31'd0, op_ready}, 32'd1);
    op_valid = 1'b0;
  endtask

  task automatic t_same_cycle();
    do_reset();
    issue("R9", 2'd0, 16'h10, 16'h4, 16'h0, 16'h0, 16'h0, 16'h0);
    put(2'd0, 16'hA0, 16'h4, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R9", "busy before done", {31'd0, op_ready}, 32'd0);
    res_done = 3'b001;
    #1;
    chk("R9", "ready with done", {31'd0, op_ready}, 32'd1);
    @(negedge clk);
    res_done = '0; op_valid = 1'b0;
    #1;
    chk("R9", "refill dispatched", {29'd0, disp_valid}, 32'd1);
    chk("R9", "refill payload", {16'd0, disp_wr_base}, 32'hA0);
    put(2'd0, 16'hC0, 16'h4, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R9", "refilled slot busy", {31'd0, op_ready}, 32'd0);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_dispatch();
    t_busy();
    t_parallel();
    t_raw();
    t_war();
    t_waw();
    t_zero();
    t_bad_res();
    t_idle_done();
    t_same_cycle();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule